// File: doc/BRIEF.md
# Half-Duplex Infrared Link Direction Guard

This block decides which way a half-duplex infrared link attached to a UART may carry traffic. A shared optical path echoes a station's own transmission back into its receiver, and a remote station needs time to turn around. After each burst of activity in either direction, the block therefore holds the link for a programmable guard time. It only watches the UART's activity strobes and its transmit-buffer flag. It drives two gates: one lets the receiver accept input, the other lets the transmitter start a character.

The link is in one of five states. In the idle state both directions are open. Transmit activity is a pending byte that leaves idle, followed by the strobe marking the final bit sent. During transmit activity, and during the guard time after it, the receiver is blocked. Receive activity is a start-bit detect, followed by a character-complete strobe. During receive activity, and during the guard time after it, a pending transmit is held off. New activity of the same kind during a guard ends that guard, and a fresh guard starts when the new character finishes. The guard setting counts 100 µs ticks. A prescaler derives the tick from the system clock frequency parameter.

Top module: `ir_turnaround_timer`

## Requirements
- R1: After reset deasserts, with half-duplex operation enabled, both `rx_enable` and `tx_permit` read 1 (idle state).
- R2: While `hdx_en` is 0, `rx_enable` and `tx_permit` are both 1 in every cycle, whatever the activity inputs do.
- R3: A `tx_last` pulse ends transmit activity. `rx_enable` then stays 0 for exactly `min(guard_cfg,100) × CLK_HZ/10000` clock cycles, counted from the clock edge that samples the strobe, and returns to 1 at the last edge of that span.
- R4: A `rx_start` pulse during the post-transmit guard is ignored. `rx_enable` stays 0, and when the guard expires, `tx_permit` is 1.
- R5: If `tx_pend` rises during the post-transmit guard, the guard ends, transmit activity resumes with `tx_permit` at 1, and the next `tx_last` starts a full-length guard again.
- R6: A `rx_start` pulse in the idle state (with `tx_pend` at 0) makes `tx_permit` 0. It stays 0 until the guard that follows `rx_done` has run its full length.
- R7: Transmit data that becomes pending while a character is being received waits. `tx_permit` stays 0 until the post-receive guard expires, and then becomes 1.
- R8: A `rx_start` pulse during the post-receive guard ends that guard. The next `rx_done` starts a full-length guard again.
- R9: With `guard_cfg` at 0 there is no guard time. The link is idle (both outputs 1) from the edge that samples `tx_last` or `rx_done`.
- R10: A `guard_cfg` value above 100 acts as 100 ticks, which is 10 ms.
- R11: One tick lasts `CLK_HZ/10000` clock cycles. With `guard_cfg` at 1, the guard lasts exactly that many cycles.
- R12: Once a pending byte leaves the idle state, `rx_enable` is 0 for the whole transmission. `rx_enable` and `tx_permit` are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency given by `CLK_HZ` |
| rst_n | input | 1 | Synchronous active-low reset |
| hdx_en | input | 1 | 1 selects half-duplex guarding; 0 opens both directions |
| guard_cfg | input | 8 | Guard time in 100 µs ticks; values above 100 act as 100 |
| tx_pend | input | 1 | Level: the transmit buffer holds a byte waiting to be sent |
| tx_last | input | 1 | One-cycle strobe: last bit of a transmitted character sent |
| rx_start | input | 1 | One-cycle strobe: receive start bit detected |
| rx_done | input | 1 | One-cycle strobe: last bit of a received character taken in |
| rx_enable | output | 1 | 1 lets the receiver accept line input |
| tx_permit | output | 1 | 1 lets the transmitter start a character |

## Verification
A wrong internal state shows first as a gate opening or closing at the wrong edge. A guard counter that is off by one tick moves the release of `rx_enable` or `tx_permit` by exactly `CLK_HZ/10000` cycles. A prescaler that is off by one moves it by `guard_cfg` cycles. The tests therefore sample the cycle before the expected release as well as the release cycle itself. A state machine that jumps to the wrong direction shows one cycle after the offending strobe, as the wrong gate going low. A state machine that fails to restart a guard shows as an early release, within one guard length of the restart.

// File: rtl/ir_turnaround_pkg.sv
// Package: shared types and helpers for the IR turnaround timer.
// Assumes the guard setting is expressed in 100 us ticks with a hard ceiling.
package ir_turnaround_pkg;

    localparam int GUARD_MAX_TICKS = 100;
    localparam int GUARD_W         = 7;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_TX_ACT   = 3'd1,
        ST_TX_GUARD = 3'd2,
        ST_RX_ACT   = 3'd3,
        ST_RX_GUARD = 3'd4
    } dir_state_e;

    // Limit a raw 8-bit setting to the maximum tick count.
    function automatic logic [GUARD_W-1:0] clamp_guard(input logic [7:0] raw);
        if (raw > 8'(GUARD_MAX_TICKS))
            return GUARD_W'(GUARD_MAX_TICKS);
        else
            return raw[GUARD_W-1:0];
    endfunction

endpackage

// File: rtl/ir_tick_prescaler.sv
// Module: ir_tick_prescaler
// Emits a one-cycle tick every TICK_CYCLES clocks while run is high.
// clr restarts the phase so that the first tick follows exactly TICK_CYCLES
// clocks later. Assumes TICK_CYCLES >= 1.
module ir_tick_prescaler #(
    parameter int TICK_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] phase_q;

    // Purpose: count clock cycles within the current tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign tick = run && !clr && (phase_q == LAST);

endmodule

// File: rtl/ir_guard_counter.sv
// Module: ir_guard_counter
// Holds the remaining guard ticks. load takes a fresh count, and each tick
// takes one away. expire pulses on the tick that consumes the final unit.
// Assumes load and tick are never both high (the prescaler is cleared on load).
module ir_guard_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] remain,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    // Purpose: load the guard length or step it down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign remain = cnt_q;
    assign expire = tick && (cnt_q == W'(1));

endmodule

// File: rtl/ir_dir_fsm.sv
// Module: ir_dir_fsm
// Tracks which direction owns the link. The last active side keeps it through
// its guard, and the gates follow the state. Transmit wins over receive when
// both request from idle in the same cycle. Assumes single-cycle strobes.
module ir_dir_fsm
    import ir_turnaround_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hdx_en,
    input  logic       tx_pend,
    input  logic       tx_last,
    input  logic       rx_start,
    input  logic       rx_done,
    input  logic       guard_zero,
    input  logic       expire,
    output dir_state_e state,
    output logic       load_timer,
    output logic       guard_run,
    output logic       rx_enable,
    output logic       tx_permit
);
    dir_state_e state_q, state_d;

    // Purpose: choose the next owner of the link.
    always_comb begin
        state_d    = state_q;
        load_timer = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_pend)       state_d = ST_TX_ACT;
                else if (rx_start) state_d = ST_RX_ACT;
            end
            ST_TX_ACT: begin
                if (tx_last) begin
                    state_d    = guard_zero ? ST_IDLE : ST_TX_GUARD;
                    load_timer = !guard_zero;
                end
            end
            ST_TX_GUARD: begin
                if (tx_pend)     state_d = ST_TX_ACT;
                else if (expire) state_d = ST_IDLE;
            end
            ST_RX_ACT: begin
                if (rx_done) begin
                    state_d    = guard_zero ? ST_IDLE : ST_RX_GUARD;
                    load_timer = !guard_zero;
                end
            end
            ST_RX_GUARD: begin
                if (rx_start)    state_d = ST_RX_ACT;
                else if (expire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!hdx_en) begin
            state_d    = ST_IDLE;
            load_timer = 1'b0;
        end
    end

    // Purpose: register the link owner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign state     = state_q;
    assign guard_run = hdx_en && (state_q == ST_TX_GUARD || state_q == ST_RX_GUARD);
    assign rx_enable = !hdx_en || !(state_q == ST_TX_ACT || state_q == ST_TX_GUARD);
    assign tx_permit = !hdx_en || !(state_q == ST_RX_ACT || state_q == ST_RX_GUARD);

endmodule

// File: rtl/ir_turnaround_timer.sv
// Module: ir_turnaround_timer (top)
// Half-duplex IR direction guard. It combines the tick prescaler, the guard
// counter and the direction state machine. Assumes the activity strobes are
// synchronous to clk and one cycle wide, and that tx_pend is a level.
module ir_turnaround_timer
    import ir_turnaround_pkg::*;
#(
    parameter int CLK_HZ  = 125_000_000,
    parameter int TICK_HZ = 10_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hdx_en,
    input  logic [7:0] guard_cfg,
    input  logic       tx_pend,
    input  logic       tx_last,
    input  logic       rx_start,
    input  logic       rx_done,
    output logic       rx_enable,
    output logic       tx_permit
);
    localparam int TICK_CYCLES = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

    dir_state_e           state_q;
    logic [GUARD_W-1:0]   guard_len;
    logic [GUARD_W-1:0]   guard_cnt;
    logic                 load_timer;
    logic                 guard_run;
    logic                 tick;
    logic                 expire;

    assign guard_len = clamp_guard(guard_cfg);

    ir_tick_prescaler #(.TICK_CYCLES(TICK_CYCLES)) presc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (load_timer),
        .run  (guard_run),
        .tick (tick)
    );

    ir_guard_counter #(.W(GUARD_W)) guard_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_timer),
        .load_val(guard_len),
        .tick    (tick),
        .remain  (guard_cnt),
        .expire  (expire)
    );

    ir_dir_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdx_en    (hdx_en),
        .tx_pend   (tx_pend),
        .tx_last   (tx_last),
        .rx_start  (rx_start),
        .rx_done   (rx_done),
        .guard_zero(guard_len == '0),
        .expire    (expire),
        .state     (state_q),
        .load_timer(load_timer),
        .guard_run (guard_run),
        .rx_enable (rx_enable),
        .tx_permit (tx_permit)
    );

endmodule

// File: rtl/ir_turnaround_chk.sv
// Module: ir_turnaround_chk
// Property checker for ir_turnaround_timer, attached with bind below.
module ir_turnaround_chk
    import ir_turnaround_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                hdx_en,
    input logic [7:0]          guard_cfg,
    input logic                tx_last,
    input logic                rx_done,
    input logic                rx_enable,
    input logic                tx_permit,
    input dir_state_e          state,
    input logic [GUARD_W-1:0]  guard_cnt
);
    // R2
    hdx_off_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdx_en |-> (rx_enable && tx_permit));

    // R3
    tx_guard_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdx_en && state == ST_TX_ACT && tx_last && guard_cfg != 8'd0)
        |=> (!rx_enable || !hdx_en));

    // R4
    tx_guard_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_GUARD) |=> (state != ST_RX_ACT));

    // R6
    rx_guard_holds_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdx_en && state == ST_RX_ACT && rx_done && guard_cfg != 8'd0)
        |=> (!tx_permit || !hdx_en));

    // R10
    guard_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        guard_cnt <= GUARD_W'(GUARD_MAX_TICKS));

    // R12
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable || tx_permit));

endmodule

bind ir_turnaround_timer ir_turnaround_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdx_en   (hdx_en),
    .guard_cfg(guard_cfg),
    .tx_last  (tx_last),
    .rx_done  (rx_done),
    .rx_enable(rx_enable),
    .tx_permit(tx_permit),
    .state    (state_q),
    .guard_cnt(guard_cnt)
);

// File: tb/ir_turnaround_timer_tb.sv
// Directed bench for ir_turnaround_timer. One task per scenario.
// CLK_HZ is overridden so that one tick is 10 clock cycles.
module ir_turnaround_timer_tb_top;

    localparam int CLK_HZ = 100_000;
    localparam int TICK   = CLK_HZ / 10_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdx_en = 1'b1;
    logic [7:0] guard_cfg = 8'd2;
    logic       tx_pend = 1'b0;
    logic       tx_last = 1'b0;
    logic       rx_start = 1'b0;
    logic       rx_done = 1'b0;
    logic       rx_enable;
    logic       tx_permit;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ir_turnaround_timer #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdx_en   (hdx_en),
        .guard_cfg(guard_cfg),
        .tx_pend  (tx_pend),
        .tx_last  (tx_last),
        .rx_start (rx_start),
        .rx_done  (rx_done),
        .rx_enable(rx_enable),
        .tx_permit(tx_permit)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_tx();
        tx_pend = 1'b1; cyc(1); tx_pend = 1'b0;
    endtask
    task automatic pulse_tx_last();
        tx_last = 1'b1; cyc(1); tx_last = 1'b0;
    endtask
    task automatic pulse_rx_start();
        rx_start = 1'b1; cyc(1); rx_start = 1'b0;
    endtask
    task automatic pulse_rx_done();
        rx_done = 1'b1; cyc(1); rx_done = 1'b0;
    endtask

    // Guard after tx: rx_enable low for len cycles after the strobe edge.
    task automatic tx_guard_span(input string req, input int len);
        cyc(len - 1);
        check(req, "rx_enable one cycle before tx guard end", rx_enable, 1'b0);
        cyc(1);
        check(req, "rx_enable at tx guard end", rx_enable, 1'b1);
    endtask

    task automatic rx_guard_span(input string req, input int len);
        cyc(len - 1);
        check(req, "tx_permit one cycle before rx guard end", tx_permit, 1'b0);
        cyc(1);
        check(req, "tx_permit at rx guard end", tx_permit, 1'b1);
    endtask

    task automatic t_reset();
        check("R1", "rx_enable after reset", rx_enable, 1'b1);
        check("R1", "tx_permit after reset", tx_permit, 1'b1);
    endtask

    task automatic t_disabled();
        hdx_en = 1'b0;
        cyc(1);
        start_tx();
        check("R2", "rx_enable disabled after load", rx_enable, 1'b1);
        pulse_rx_start();
        check("R2", "tx_permit disabled after rx start", tx_permit, 1'b1);
        pulse_tx_last();
        check("R2", "rx_enable disabled after tx last", rx_enable, 1'b1);
        pulse_rx_done();
        check("R2", "tx_permit disabled after rx done", tx_permit, 1'b1);
        hdx_en = 1'b1;
        cyc(2);
    endtask

    task automatic t_tx_guard();
        guard_cfg = 8'd3;
        start_tx();
        check("R12", "rx_enable while transmitting", rx_enable, 1'b0);
        check("R12", "tx_permit while transmitting", tx_permit, 1'b1);
        cyc(4);
        check("R12", "rx_enable mid transmission", rx_enable, 1'b0);
        pulse_tx_last();
        tx_guard_span("R3", 3 * TICK);
        guard_cfg = 8'd1;
        start_tx();
        pulse_tx_last();
        tx_guard_span("R11", TICK);
    endtask

    task automatic t_tx_ignore_rx();
        guard_cfg = 8'd2;
        start_tx();
        pulse_tx_last();
        cyc(4);
        pulse_rx_start();
        check("R4", "rx_enable after rx_start in tx guard", rx_enable, 1'b0);
        check("R4", "tx_permit after rx_start in tx guard", tx_permit, 1'b1);
        tx_guard_span("R4", 2 * TICK - 5);
        check("R4", "tx_permit after tx guard expiry", tx_permit, 1'b1);
    endtask

    task automatic t_tx_reload();
        guard_cfg = 8'd2;
        start_tx();
        pulse_tx_last();
        cyc(9);
        start_tx();
        check("R5", "tx_permit after reload", tx_permit, 1'b1);
        check("R5", "rx_enable after reload", rx_enable, 1'b0);
        cyc(15);
        check("R5", "rx_enable past old guard end", rx_enable, 1'b0);
        pulse_tx_last();
        tx_guard_span("R5", 2 * TICK);
    endtask

    task automatic t_rx_guard();
        guard_cfg = 8'd2;
        pulse_rx_start();
        check("R6", "tx_permit while receiving", tx_permit, 1'b0);
        check("R6", "rx_enable while receiving", rx_enable, 1'b1);
        cyc(5);
        pulse_rx_done();
        rx_guard_span("R6", 2 * TICK);
    endtask

    task automatic t_rx_hold_tx();
        guard_cfg = 8'd2;
        pulse_rx_start();
        tx_pend = 1'b1;
        cyc(3);
        check("R7", "tx_permit with pending tx during rx", tx_permit, 1'b0);
        pulse_rx_done();
        rx_guard_span("R7", 2 * TICK);
        cyc(1);
        check("R7", "rx_enable once held tx starts", rx_enable, 1'b0);
        tx_pend = 1'b0;
        pulse_tx_last();
        tx_guard_span("R7", 2 * TICK);
    endtask

    task automatic t_rx_restart();
        guard_cfg = 8'd2;
        pulse_rx_start();
        pulse_rx_done();
        cyc(9);
        pulse_rx_start();
        check("R8", "tx_permit after restart rx", tx_permit, 1'b0);
        cyc(15);
        check("R8", "tx_permit past old guard end", tx_permit, 1'b0);
        pulse_rx_done();
        rx_guard_span("R8", 2 * TICK);
    endtask

    task automatic t_zero();
        guard_cfg = 8'd0;
        start_tx();
        pulse_tx_last();
        check("R9", "rx_enable right after tx last", rx_enable, 1'b1);
        check("R9", "tx_permit right after tx last", tx_permit, 1'b1);
        pulse_rx_start();
        pulse_rx_done();
        check("R9", "tx_permit right after rx done", tx_permit, 1'b1);
        check("R9", "rx_enable right after rx done", rx_enable, 1'b1);
    endtask

    task automatic t_clamp();
        guard_cfg = 8'd250;
        start_tx();
        pulse_tx_last();
        tx_guard_span("R10", 100 * TICK);
    endtask

    initial begin : watchdog
        repeat (100_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_disabled();
        t_tx_guard();
        t_tx_ignore_rx();
        t_tx_reload();
        t_rx_guard();
        t_rx_hold_tx();
        t_rx_restart();
        t_zero();
        t_clamp();
        cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule